// File: doc/BRIEF.md
# Background Flash Stream Prefetcher

This engine moves a contiguous run of 32-bit words out of flash into a two-entry streaming buffer while nothing else is using the flash. Software first loads a word-aligned start address and then a nonzero word count. From then on the engine raises a read request on each cycle in which the flash port reports itself idle, provided the buffer can still take the returning word. Each request moves the address forward by one word and takes one off the remaining count. Returning words enter the buffer in order, and a DMA or a processor drains them through a pop port.

Loading a count of zero stops the stream in that same cycle. Every read still outstanding at that moment is marked for discard, and its response is dropped when it arrives. A new address and count can be loaded straight away. The fill level can be read from full and empty flags. A pop on an empty buffer yields zero and changes nothing.

Top module: `flash_stream_prefetch`

## Requirements
- R1: After a synchronous reset, stream_addr and stream_cnt are 0, fifo_empty is 1, fifo_full is 0, pop_data is 0 and fl_req is low.
- R2: An address write keeps only bits 31:2 of addr_wr_data. stream_addr bits 1:0 always read 0, and the new value shows on stream_addr one cycle after the write.
- R3: fl_req is asserted only in a cycle where fl_idle is high and stream_cnt is nonzero. A nonzero count write starts the stream, and the first request can come on the cycle after that write.
- R4: fl_addr equals stream_addr during a request. After each request without a write, stream_addr grows by 4 and stream_cnt falls by 1. No request is made while stream_cnt is 0.
- R5: Each response that is not discarded is stored, and words come out in request order. A pop loads the oldest word into pop_data one cycle later. pop_data holds its value in cycles without a pop.
- R6: A request is made only if the words stored plus the live reads outstanding come to fewer than 2, and only if fewer than 15 reads in total are outstanding.
- R7: A count write of zero blocks any request in that cycle. Every read outstanding at that edge, including one whose response arrives in the same cycle, has its response dropped and never stored.
- R8: fifo_empty is 1 exactly when 0 words are stored, and fifo_full is 1 exactly when 2 words are stored.
- R9: A pop when no word is stored loads 0 into pop_data and leaves the stored words and the flags unchanged.
- R10: Any count write suppresses a request in its cycle. An address write in the same cycle as a request still sends the old address, and the written value is loaded afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_wr_en | input | 1 | Write strobe for the stream address |
| addr_wr_data | input | 32 | Address write value |
| cnt_wr_en | input | 1 | Write strobe for the word count |
| cnt_wr_data | input | 22 | Count write value; zero aborts |
| stream_addr | output | 32 | Next word address to fetch |
| stream_cnt | output | 22 | Words still to be requested |
| fl_idle | input | 1 | Flash port free this cycle |
| fl_req | output | 1 | Read request, accepted in the cycle it is high |
| fl_addr | output | 32 | Byte address of the request |
| fl_rsp_valid | input | 1 | Read data returning, in request order |
| fl_rsp_data | input | 32 | Returned word |
| pop_en | input | 1 | Take one word from the buffer |
| pop_data | output | 32 | Popped word, registered |
| fifo_full | output | 1 | Buffer holds 2 words |
| fifo_empty | output | 1 | Buffer holds no words |

## Verification
fl_req and fl_addr are combinational from registered state and fl_idle. The bench reads them 1 ns after it drives the inputs, in the same cycle. stream_addr, stream_cnt, the two flags and pop_data each pass through one register, so each is compared at the falling edge after the rising edge that takes in the stimulus. A behavioural model built on queues predicts all of these values every cycle, including the cycle of an abort and the later responses that must be dropped. The flash model feeds responses back with a random, in-order latency.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned SP_BYTES_PER_WORD = 4;
  localparam int unsigned SP_BYTE_BITS      = 2;
endpackage

// File: rtl/sp_fifo.sv
module sp_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic              take;

  assign take  = pop && (level != '0);
  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      level    <= '0;
      pop_data <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (take) rptr <= bump(rptr);
      if (pop)  pop_data <= take ? mem[rptr] : '0;
      level <= level + LVL_W'(push) - LVL_W'(take);
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    push |-> (level != LVL_W'(DEPTH)));
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (pop_data == '0) && (level == '0));
endmodule

// File: rtl/sp_inflight_track.sv
module sp_inflight_track #(
  parameter int unsigned DEPTH    = 2,
  parameter int unsigned MAX_PEND = 15,
  localparam int unsigned LVL_W   = $clog2(DEPTH + 1),
  localparam int unsigned PEND_W  = $clog2(MAX_PEND + 1),
  localparam int unsigned SUM_W   = ((PEND_W > LVL_W) ? PEND_W : LVL_W) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             abort,
  input  logic             rsp_valid,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             room,
  output logic             push
);
  logic [PEND_W-1:0] pend, drop, eff_drop, live;
  logic              rsp_ok;
  logic [SUM_W-1:0]  used;

  assign live     = pend - drop;
  assign used     = SUM_W'(fifo_level) + SUM_W'(live);
  assign room     = (used < SUM_W'(DEPTH)) && (pend != PEND_W'(MAX_PEND));
  assign rsp_ok   = rsp_valid && (pend != '0);
  assign eff_drop = abort ? pend : drop;
  assign push     = rsp_ok && (eff_drop == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      drop <= '0;
    end else begin
      pend <= pend + PEND_W'(issue) - PEND_W'(rsp_ok);
      drop <= eff_drop - PEND_W'(rsp_ok && (eff_drop != '0));
    end
  end

  p_drop_bound_r7: assert property (@(posedge clk) disable iff (rst)
    drop <= pend);
  p_abort_marks_r7: assert property (@(posedge clk) disable iff (rst)
    abort |=> (drop == $past(pend) - PEND_W'($past(rsp_ok))));
endmodule

// File: rtl/sp_issue_ctrl.sv
module sp_issue_ctrl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 22,
  localparam int unsigned WA_W  = ADDR_W - sp_pkg::SP_BYTE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              flash_idle,
  input  logic              room,
  output logic              issue,
  output logic              abort,
  output logic [WA_W-1:0]   word_addr,
  output logic [CNT_W-1:0]  count
);
  assign abort = cnt_wr && (cnt_wdata == '0);
  assign issue = (count != '0) && flash_idle && !cnt_wr && room;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_addr <= '0;
      count     <= '0;
    end else begin
      if (addr_wr)    word_addr <= addr_wdata[ADDR_W-1:sp_pkg::SP_BYTE_BITS];
      else if (issue) word_addr <= word_addr + 1'b1;
      if (cnt_wr)     count <= cnt_wdata;
      else if (issue) count <= count - 1'b1;
    end
  end

  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (issue && !addr_wr) |=> (word_addr == $past(word_addr) + 1'b1));
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    (issue && !cnt_wr) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/flash_stream_prefetch.sv
module flash_stream_prefetch #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 22,
  parameter int unsigned DEPTH    = 2,
  parameter int unsigned MAX_PEND = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_wr_en,
  input  logic [ADDR_W-1:0] addr_wr_data,
  input  logic              cnt_wr_en,
  input  logic [CNT_W-1:0]  cnt_wr_data,
  output logic [ADDR_W-1:0] stream_addr,
  output logic [CNT_W-1:0]  stream_cnt,
  input  logic              fl_idle,
  output logic              fl_req,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic              fl_rsp_valid,
  input  logic [DATA_W-1:0] fl_rsp_data,
  input  logic              pop_en,
  output logic [DATA_W-1:0] pop_data,
  output logic              fifo_full,
  output logic              fifo_empty
);
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);
  localparam int unsigned WA_W  = ADDR_W - sp_pkg::SP_BYTE_BITS;

  logic             issue, abort, room, push;
  logic [WA_W-1:0]  word_addr;
  logic [LVL_W-1:0] level;

  sp_issue_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .addr_wr(addr_wr_en), .addr_wdata(addr_wr_data),
    .cnt_wr(cnt_wr_en), .cnt_wdata(cnt_wr_data),
    .flash_idle(fl_idle), .room(room),
    .issue(issue), .abort(abort),
    .word_addr(word_addr), .count(stream_cnt)
  );

  sp_inflight_track #(.DEPTH(DEPTH), .MAX_PEND(MAX_PEND)) u_track (
    .clk(clk), .rst(rst),
    .issue(issue), .abort(abort), .rsp_valid(fl_rsp_valid),
    .fifo_level(level), .room(room), .push(push)
  );

  sp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .push_data(fl_rsp_data),
    .pop(pop_en), .pop_data(pop_data),
    .level(level), .full(fifo_full), .empty(fifo_empty)
  );

  assign stream_addr = {word_addr, {sp_pkg::SP_BYTE_BITS{1'b0}}};
  assign fl_addr     = stream_addr;
  assign fl_req      = issue;
endmodule

// File: tb/flash_stream_prefetch_tb.sv
`timescale 1ns/1ps
module flash_stream_prefetch_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_wr_en = 1'b0;
  logic [31:0] addr_wr_data = '0;
  logic        cnt_wr_en = 1'b0;
  logic [21:0] cnt_wr_data = '0;
  logic [31:0] stream_addr;
  logic [21:0] stream_cnt;
  logic        fl_idle = 1'b0;
  logic        fl_req;
  logic [31:0] fl_addr;
  logic        fl_rsp_valid = 1'b0;
  logic [31:0] fl_rsp_data = '0;
  logic        pop_en = 1'b0;
  logic [31:0] pop_data;
  logic        fifo_full, fifo_empty;

  always #2 clk = ~clk;

  flash_stream_prefetch dut_i (
    .clk(clk), .rst(rst),
    .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .stream_addr(stream_addr), .stream_cnt(stream_cnt),
    .fl_idle(fl_idle), .fl_req(fl_req), .fl_addr(fl_addr),
    .fl_rsp_valid(fl_rsp_valid), .fl_rsp_data(fl_rsp_data),
    .pop_en(pop_en), .pop_data(pop_data),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_due = 0;
  int idle_mode = 0;   // 0 always idle, 1 random, 2 never
  int lat_max = 1;

  logic [31:0] m_addr = '0;
  int          m_cnt = 0;
  logic [31:0] m_q[$];
  int          m_pend = 0;
  int          m_drop = 0;
  logic [31:0] m_pop = '0;
  logic [31:0] fq_addr[$];
  int          fq_due[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check_regs();
    chk(stream_addr == m_addr, "R2/R4 stream_addr", stream_addr, m_addr);
    chk(stream_cnt == 22'(m_cnt), "R4 stream_cnt", 32'(stream_cnt), 32'(m_cnt));
    chk(fifo_empty == (m_q.size() == 0), "R8 fifo_empty", 32'(fifo_empty), 32'(m_q.size() == 0));
    chk(fifo_full == (m_q.size() == 2), "R8 fifo_full", 32'(fifo_full), 32'(m_q.size() == 2));
    chk(pop_data == m_pop, "R5/R9 pop_data", pop_data, m_pop);
  endtask

  // One clock: inputs set by caller, flash model and reference model here.
  task automatic step();
    bit exp_issue, rsp, abort;
    int eff_drop, due;
    case (idle_mode)
      0: fl_idle = 1'b1;
      1: fl_idle = 1'($urandom % 2);
      default: fl_idle = 1'b0;
    endcase
    rsp = (fq_due.size() > 0) && (fq_due[0] <= cyc);
    fl_rsp_valid = rsp;
    fl_rsp_data = rsp ? (fq_addr[0] ^ 32'h5A5A_C3C3) : 32'h0;
    if (rsp) begin
      void'(fq_addr.pop_front());
      void'(fq_due.pop_front());
    end
    #1;
    exp_issue = (m_cnt != 0) && fl_idle && !cnt_wr_en &&
                (m_q.size() + m_pend - m_drop < 2) && (m_pend < 15);
    chk(fl_req == exp_issue, "R3/R6/R7/R10 fl_req", 32'(fl_req), 32'(exp_issue));
    if (exp_issue) begin
      chk(fl_addr == m_addr, "R4/R10 fl_addr", fl_addr, m_addr);
      due = cyc + 1 + int'($urandom % lat_max);
      if (due <= last_due) due = last_due + 1;
      last_due = due;
      fq_addr.push_back(m_addr);
      fq_due.push_back(due);
    end
    abort = cnt_wr_en && (cnt_wr_data == 0);
    eff_drop = abort ? m_pend : m_drop;
    if (pop_en) begin
      if (m_q.size() > 0) m_pop = m_q.pop_front();
      else m_pop = 32'h0;
    end
    if (rsp) begin
      if (eff_drop > 0) eff_drop--;
      else m_q.push_back(fl_rsp_data);
    end
    m_pend = m_pend + int'(exp_issue) - int'(rsp);
    m_drop = eff_drop;
    if (addr_wr_en) m_addr = {addr_wr_data[31:2], 2'b00};
    else if (exp_issue) m_addr = m_addr + 32'd4;
    if (cnt_wr_en) m_cnt = int'(cnt_wr_data);
    else if (exp_issue) m_cnt = m_cnt - 1;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    addr_wr_en = 1'b0;
    cnt_wr_en = 1'b0;
    pop_en = 1'b0;
    check_regs();
  endtask

  task automatic run(input int n, input int pop_pct);
    for (int i = 0; i < n; i++) begin
      pop_en = (int'($urandom % 100) < pop_pct);
      step();
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'(cyc), 32'h0);
    finish_run();
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(stream_addr == 0 && stream_cnt == 0, "R1 regs", stream_addr, 32'h0);
    chk(fifo_empty == 1'b1 && fifo_full == 1'b0, "R1 flags", {fifo_full, fifo_empty}, 32'h1);
    chk(fl_req == 1'b0 && pop_data == 0, "R1 req/pop", pop_data, 32'h0);

    // R2: low address bits discarded
    addr_wr_en = 1'b1; addr_wr_data = 32'h1000_0003;
    step();
    chk(stream_addr[1:0] == 2'b00, "R2 low bits", stream_addr, 32'h1000_0000);

    // R9: pop empty
    pop_en = 1'b1; step();
    chk(pop_data == 0 && fifo_empty, "R9 empty pop", pop_data, 32'h0);

    // R3/R6/R8: stream of 5, no pops, fills and stalls
    idle_mode = 0; lat_max = 1;
    cnt_wr_en = 1'b1; cnt_wr_data = 22'd5; step();
    run(8, 0);
    chk(fifo_full == 1'b1 && stream_cnt == 22'd3, "R6 stall when full", 32'(stream_cnt), 32'd3);
    run(30, 50);

    // R3: never idle, no requests
    idle_mode = 2;
    cnt_wr_en = 1'b1; cnt_wr_data = 22'd4; step();
    run(6, 0);
    chk(stream_cnt == 22'd4, "R3 no idle no req", 32'(stream_cnt), 32'd4);

    // R5: random idle, long latency, random pops
    idle_mode = 1; lat_max = 4;
    run(60, 40);
    cnt_wr_en = 1'b1; cnt_wr_data = 22'd20; step();
    run(120, 45);
    run(20, 100);

    // R7: abort with reads outstanding
    idle_mode = 0; lat_max = 5;
    addr_wr_en = 1'b1; addr_wr_data = 32'h2000_0000;
    cnt_wr_en = 1'b1; cnt_wr_data = 22'd10; step();
    step();
    cnt_wr_en = 1'b1; cnt_wr_data = 22'd0; step();
    run(8, 0);
    chk(fifo_empty == 1'b1, "R7 discarded responses", 32'(fifo_empty), 32'h1);
    // new stream right away
    addr_wr_en = 1'b1; addr_wr_data = 32'h3000_0010;
    cnt_wr_en = 1'b1; cnt_wr_data = 22'd6; step();
    run(40, 60);

    // R10: addr write during a request, count rewrite blocks request
    cnt_wr_en = 1'b1; cnt_wr_data = 22'd3; step();
    addr_wr_en = 1'b1; addr_wr_data = 32'h4000_0100; step();
    chk(stream_addr == 32'h4000_0100, "R10 addr write wins", stream_addr, 32'h4000_0100);
    cnt_wr_en = 1'b1; cnt_wr_data = 22'd7; #1;
    chk(fl_req == 1'b0, "R10 cnt write blocks req", 32'(fl_req), 32'h0);
    step();
    run(40, 70);

    // mixed random run with aborts and restarts
    idle_mode = 1; lat_max = 6;
    for (int k = 0; k < 30; k++) begin
      addr_wr_en = ($urandom % 4 == 0);
      addr_wr_data = $urandom;
      cnt_wr_en = 1'b1;
      cnt_wr_data = ($urandom % 3 == 0) ? 22'd0 : 22'($urandom % 12);
      step();
      run(int'($urandom % 25), 50);
    end
    idle_mode = 2;
    run(20, 100);
    finish_run();
  end
endmodule